// File: doc/BRIEF.md
# Partial-Word Load Merge Unit

This unit carries out the four partial-word loads that fill one end of a register from an unaligned address: a left and a right form for 32-bit words, and a left and a right form for 64-bit doublewords. A request brings an effective address, an operation code and the destination register's present value. The unit makes one aligned read from memory. It shifts the returned data into position and combines it with the bytes of the old register value that the operation leaves alone. The merged 64-bit value is then returned with a one-cycle valid strobe.

The byte order is fixed when the unit is built, through a parameter. An unaligned word or doubleword is normally loaded by a left/right pair on the two ends of the span. Each half costs one memory access, whatever the offset. Memory sits behind a plain request/response port whose latency may vary. The unit takes one request at a time.

Top module: `partial_load_merge`

## Requirements
- R1: After reset, `res_valid` and `mem_req` are low and `req_ready` is high.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `mem_req` is high for exactly one cycle, the cycle after the request is taken. While `req_ready` is low, `req_valid` and the request fields are ignored.
- R3: `mem_addr` is the request address with its low 2 bits cleared for word operations, or its low 3 bits cleared for doubleword operations. `mem_dword` is 1 for doubleword reads. A word read returns its word, zero-extended, in bits 31:0 of `mem_rsp_data`.
- R4: Operation codes are: 2'b00 word-left, 2'b01 word-right, 2'b10 doubleword-left, 2'b11 doubleword-right. The byte offset is the low 2 (word) or 3 (doubleword) address bits. With `BIG_END`=0 the left forms invert the offset (XOR 3 or 7). With `BIG_END`=1 the right forms invert it instead. The shift is eight times the corrected offset.
- R5: Left forms shift the memory data left by the shift amount. The low shift-amount bits of the old value are kept.
- R6: Right forms shift the memory data right by the shift amount. The bits of the old value above what the shifted data covers, within the word or doubleword, are kept.
- R7: The word-left result is sign-extended from bit 31 to 64 bits. The word-right result keeps bits 63:32 of the old value unchanged.
- R8: `res_valid` is a single-cycle pulse. It is raised in the cycle after the edge on which `mem_rsp_valid` is sampled high while a read is outstanding. `req_ready` is high again in that same cycle.
- R9: When the corrected offset is zero, the whole word or doubleword comes from memory and no old bits within it survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code (see R4) |
| req_addr | input | ADDR_W | Effective byte address |
| req_old | input | 64 | Current destination register value |
| req_ready | output | 1 | Unit idle, request can be taken |
| mem_req | output | 1 | Aligned read request, one cycle |
| mem_addr | output | ADDR_W | Aligned read address |
| mem_dword | output | 1 | 1 = doubleword read, 0 = word read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| res_valid | output | 1 | Result strobe |
| res_data | output | 64 | Merged result |

## Verification
The assertions assume that memory raises `mem_rsp_valid` only for a read that is still outstanding, once per read, and no earlier than the cycle after `mem_req`. They also assume that the request fields are meaningful only while `req_valid` is high. The bench's memory model answers each read exactly once, after a latency of one to three cycles counted from the `mem_req` cycle. It keeps one request in flight at a time. It holds `req_valid` high with junk fields only while the unit is busy, so that R2 is tested at the ports.

// File: rtl/plm_pkg.sv
package plm_pkg;
  localparam int DW = 64;
  localparam int WW = 32;

  typedef enum logic [1:0] {
    OP_WL = 2'b00,
    OP_WR = 2'b01,
    OP_DL = 2'b10,
    OP_DR = 2'b11
  } ldop_e;

  // corrected byte offset times eight
  function automatic logic [5:0] shift_of(ldop_e op, logic [2:0] lo, logic big);
    logic [2:0] off;
    logic       inv;
    off = op[1] ? lo : {1'b0, lo[1:0]};
    inv = op[0] ? big : !big;
    if (inv) off = off ^ (op[1] ? 3'd7 : 3'd3);
    return {off, 3'b000};
  endfunction

  // bits of the old register that survive; pre-shifted constants avoid a full-width shift
  function automatic logic [DW-1:0] keep_mask(ldop_e op, logic [5:0] sh);
    logic [WW-1:0] w;
    case (op)
      OP_WL: begin
        w = 32'h7FFF_FFFF >> (sh[4:0] ^ 5'd31);
        return {32'h0, w};
      end
      OP_WR: begin
        w = 32'hFFFF_FFFE << (sh[4:0] ^ 5'd31);
        return {32'hFFFF_FFFF, w};
      end
      OP_DL:   return 64'h7FFF_FFFF_FFFF_FFFF >> (sh ^ 6'd63);
      default: return 64'hFFFF_FFFF_FFFF_FFFE << (sh ^ 6'd63);
    endcase
  endfunction

  function automatic logic [DW-1:0] place(ldop_e op, logic [DW-1:0] d, logic [5:0] sh);
    logic [WW-1:0] w;
    case (op)
      OP_WL: begin
        w = d[WW-1:0] << sh[4:0];
        return {32'h0, w};
      end
      OP_WR: begin
        w = d[WW-1:0] >> sh[4:0];
        return {32'h0, w} | {d[DW-1:WW] & 32'h0, 32'h0};
      end
      OP_DL:   return d << sh;
      default: return d >> sh;
    endcase
  endfunction

  function automatic logic [DW-1:0] combine(ldop_e op, logic [DW-1:0] placed,
                                            logic [DW-1:0] old, logic [DW-1:0] keep);
    logic [DW-1:0] r;
    r = placed | (old & keep);
    if (op == OP_WL) r[DW-1:WW] = {WW{r[WW-1]}};
    return r;
  endfunction
endpackage

// File: rtl/plm_seq.sv
module plm_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic rsp_valid,
  output logic idle,
  output logic accept,
  output logic issue,
  output logic capture
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;
  st_e st;

  assign idle    = (st == S_IDLE);
  assign accept  = idle && req_valid;
  assign issue   = (st == S_ISSUE);
  assign capture = (st == S_WAIT) && rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else begin
      case (st)
        S_IDLE:  if (req_valid) st <= S_ISSUE;
        S_ISSUE: st <= S_WAIT;
        S_WAIT:  if (rsp_valid) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  issue_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> issue);
  // R2
  single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !issue);
  // R8
  ready_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> idle);
endmodule

// File: rtl/plm_align.sv
module plm_align
  import plm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter bit BIG_END = 1'b0
) (
  input  ldop_e              op,
  input  logic [ADDR_W-1:0]  addr,
  output logic [ADDR_W-1:0]  aligned,
  output logic [5:0]         shamt
);
  logic dword;
  assign dword   = op[1];
  assign aligned = {addr[ADDR_W-1:3], dword ? 1'b0 : addr[2], 2'b00};
  assign shamt   = shift_of(op, addr[2:0], BIG_END);
endmodule

// File: rtl/plm_merge.sv
module plm_merge
  import plm_pkg::*;
(
  input  ldop_e          op,
  input  logic [5:0]     shamt,
  input  logic [DW-1:0]  rdata,
  input  logic [DW-1:0]  old,
  output logic [DW-1:0]  result
);
  logic [DW-1:0] keep;
  logic [DW-1:0] placed;
  assign keep   = keep_mask(op, shamt);
  assign placed = place(op, rdata, shamt);
  assign result = combine(op, placed, old, keep);

  always_comb begin
    // R9
    zero_shift_mask_chk: assert ((shamt != 6'd0) || op[0] || (keep[WW-1:0] == '0));
  end
endmodule

// File: rtl/partial_load_merge.sv
module partial_load_merge
  import plm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter bit BIG_END = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_old,
  output logic              req_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_dword,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              res_valid,
  output logic [63:0]       res_data
);
  ldop_e             op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     old_q;
  logic              accept, issue, capture, idle;
  logic [5:0]        shamt;
  logic [DW-1:0]     merged;

  plm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(mem_rsp_valid),
    .idle(idle), .accept(accept), .issue(issue), .capture(capture)
  );

  plm_align #(.ADDR_W(ADDR_W), .BIG_END(BIG_END)) u_align (
    .op(op_q), .addr(addr_q), .aligned(mem_addr), .shamt(shamt)
  );

  plm_merge u_merge (
    .op(op_q), .shamt(shamt), .rdata(mem_rsp_data), .old(old_q), .result(merged)
  );

  assign req_ready = idle;
  assign mem_req   = issue;
  assign mem_dword = op_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_WL;
      addr_q <= '0;
      old_q  <= '0;
    end else if (accept) begin
      op_q   <= ldop_e'(req_op);
      addr_q <= req_addr;
      old_q  <= req_old;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= capture;
      if (capture) res_data <= merged;
    end
  end

  // R8
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> ($stable(addr_q) && $stable(old_q)));
  // R3
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00 && (!mem_dword || !mem_addr[2])));
  // R7
  word_left_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && op_q == OP_WL) |=> (res_data[63:32] == {32{res_data[31]}}));
  // R7
  word_right_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && op_q == OP_WR) |=> (res_data[63:32] == old_q[63:32]));
  // R9
  full_dword_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && op_q[1] && shamt == 6'd0) |=> (res_data == $past(mem_rsp_data)));
endmodule

// File: tb/test_partial_load_merge.sv
module test_partial_load_merge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_old = '0;
  logic        rsp_valid = 1'b0;
  logic [63:0] rsp_data = '0;

  logic        rdy_le, mreq_le, mdw_le, rv_le;
  logic [31:0] maddr_le;
  logic [63:0] rd_le;
  logic        rdy_be, mreq_be, mdw_be, rv_be;
  logic [31:0] maddr_be;
  logic [63:0] rd_be;

  partial_load_merge #(.ADDR_W(32), .BIG_END(1'b0)) i_partial_load_merge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_old(req_old), .req_ready(rdy_le), .mem_req(mreq_le),
    .mem_addr(maddr_le), .mem_dword(mdw_le), .mem_rsp_valid(rsp_valid),
    .mem_rsp_data(rsp_data), .res_valid(rv_le), .res_data(rd_le));

  partial_load_merge #(.ADDR_W(32), .BIG_END(1'b1)) i_partial_load_merge_be (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_old(req_old), .req_ready(rdy_be), .mem_req(mreq_be),
    .mem_addr(maddr_be), .mem_dword(mdw_be), .mem_rsp_valid(rsp_valid),
    .mem_rsp_data(rsp_data), .res_valid(rv_be), .res_data(rd_be));

  int checks = 0;
  int errors = 0;
  int nreads = 0;

  logic [63:0] q_le[$];
  logic [63:0] q_be[$];
  string       q_tag[$];
  string       q_tagb[$];
  logic [31:0] q_addr[$];
  logic        q_dw[$];

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_image(logic [31:0] a, bit dw);
    logic [63:0] v;
    v = {a * 32'h9E37_79B1, (a ^ 32'hC3A5_96F0) * 32'h85EB_CA6B};
    return dw ? v : {32'h0, v[31:0]};
  endfunction

  // byte-at-a-time reference
  function automatic logic [63:0] ref_merge(bit be, logic [1:0] op, logic [2:0] lo,
                                            logic [63:0] d, logic [63:0] old);
    int n;
    int k;
    logic [63:0] r;
    n = op[1] ? 8 : 4;
    k = op[1] ? int'(lo) : int'(lo[1:0]);
    r = old;
    for (int i = 0; i < n; i++) begin
      int  j;
      int  dst;
      bit  take;
      if (!op[0]) begin
        dst = n - 1 - i;
        if (!be) begin take = (i <= k);         j = k - i; end
        else     begin take = (i <= n - 1 - k); j = k + i; end
      end else begin
        dst = i;
        if (!be) begin take = (i <= n - 1 - k); j = k + i; end
        else     begin take = (i <= k);         j = k - i; end
      end
      if (take) r[8*dst +: 8] = be ? d[8*(n-1-j) +: 8] : d[8*j +: 8];
    end
    if (op == 2'b00) r[63:32] = {32{r[31]}};
    return r;
  endfunction

  // memory responder, also checks the read port (R3, R2)
  always begin
    @(negedge clk);
    if (rst_n && mreq_le) begin
      logic [31:0] ea;
      logic        edw;
      int          lat;
      ea  = (q_addr.size() > 0) ? q_addr.pop_front() : 32'hDEAD_BEEF;
      edw = (q_dw.size() > 0) ? q_dw.pop_front() : 1'b0;
      chk(maddr_le == ea, "R3 aligned address (LE)", {32'h0, maddr_le}, {32'h0, ea});
      chk(maddr_be == ea && mreq_be, "R3 aligned address (BE)", {32'h0, maddr_be}, {32'h0, ea});
      chk(mdw_le == edw && mdw_be == edw, "R3 size flag", {63'h0, mdw_le}, {63'h0, edw});
      lat = 1 + (nreads % 3);
      nreads++;
      repeat (lat) begin
        @(negedge clk);
        chk(!mreq_le, "R2 single request pulse", {63'h0, mreq_le}, 64'h0);
      end
      rsp_valid = 1'b1;
      rsp_data  = mem_image(maddr_le, mdw_le);
      @(negedge clk);
      rsp_valid = 1'b0;
      rsp_data  = '0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rv_le) begin
        if (q_le.size() == 0) chk(1'b0, "R8 unexpected result (LE)", rd_le, 64'h0);
        else begin
          logic [63:0] e;
          string t;
          e = q_le.pop_front();
          t = q_tag.pop_front();
          chk(rd_le == e, {t, " little-endian"}, rd_le, e);
        end
      end
      if (rv_be) begin
        if (q_be.size() == 0) chk(1'b0, "R8 unexpected result (BE)", rd_be, 64'h0);
        else begin
          logic [63:0] e;
          string t;
          e = q_be.pop_front();
          t = q_tagb.pop_front();
          chk(rd_be == e, {t, " big-endian"}, rd_be, e);
        end
      end
    end
  end

  task automatic do_load(logic [1:0] op, logic [31:0] addr, logic [63:0] old, int linger);
    logic [31:0] al;
    logic [63:0] d;
    string       t;
    while (!rdy_le) @(negedge clk);
    al = op[1] ? {addr[31:3], 3'b000} : {addr[31:2], 2'b00};
    d  = mem_image(al, op[1]);
    case (op)
      2'b00:   t = "R4 R5 R7 word-left";
      2'b01:   t = "R4 R6 R7 word-right";
      2'b10:   t = "R4 R5 dword-left";
      default: t = "R4 R6 dword-right";
    endcase
    if (addr[1:0] == 2'b00 || addr[1:0] == 2'b11) t = {t, " R9 edge offset"};
    q_le.push_back(ref_merge(1'b0, op, addr[2:0], d, old));
    q_be.push_back(ref_merge(1'b1, op, addr[2:0], d, old));
    q_tag.push_back(t);
    q_tagb.push_back(t);
    q_addr.push_back(al);
    q_dw.push_back(op[1]);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = addr;
    req_old   = old;
    @(negedge clk);
    if (linger > 0) begin
      req_op   = ~op;
      req_addr = ~addr;
      req_old  = ~old;
      repeat (linger) @(negedge clk);
    end
    req_valid = 1'b0;
    while (q_le.size() > 0 || q_be.size() > 0) @(negedge clk);
    chk(!rv_le && !rv_be, "R8 result pulse width", {63'h0, rv_le}, 64'h0);
    chk(rdy_le && rdy_be, "R8 ready after result", {63'h0, rdy_le}, 64'h1);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog R8 actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!rv_le && !mreq_le && rdy_le, "R1 reset state (LE)", {61'h0, rv_le, mreq_le, rdy_le}, 64'h1);
    chk(!rv_be && !mreq_be && rdy_be, "R1 reset state (BE)", {61'h0, rv_be, mreq_be, rdy_be}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rv_le && !mreq_le && rdy_le, "R1 state after reset release", {61'h0, rv_le, mreq_le, rdy_le}, 64'h1);

    // every op and every offset, old value and base varied
    for (int op = 0; op < 4; op++) begin
      for (int k = 0; k < 8; k++) begin
        for (int rep = 0; rep < 3; rep++) begin
          logic [31:0] base;
          logic [63:0] old;
          base = $urandom() & 32'hFFFF_FFF8;
          old  = {$urandom(), $urandom()};
          if (rep == 1) old = 64'h0;
          if (rep == 2) old = 64'hFFFF_FFFF_FFFF_FFFF;
          do_load(op[1:0], base | k, old, 0);
        end
      end
    end

    // R2: requests held high with junk while busy must be ignored
    do_load(2'b00, 32'h0000_1001, 64'h1122_3344_5566_7788, 2);
    do_load(2'b11, 32'h0000_2005, 64'h8877_6655_4433_2211, 2);
    do_load(2'b01, 32'h0000_3006, 64'hA5A5_A5A5_5A5A_5A5A, 1);

    // R7: sign bit both ways for word-left
    do_load(2'b00, 32'h8000_0003, 64'h0, 0);
    do_load(2'b00, 32'h0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 0);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule